// File: doc/BRIEF.md
# Coherent 16-bit Register Bridge for an 8-bit Bus

This block places a bank of 16-bit timer registers behind an 8-bit processor bus so that every 16-bit value crosses the bus as one unit. The bank contains a free-running up-counter, three compare registers and a capture register. A single staging byte is shared by all five registers. Software moves a word as two byte transfers, and the staging byte makes the two halves act as one atomic load or one atomic snapshot.

To write a word, software sends the upper byte first, which lands only in the staging byte. It then sends the lower byte, and the whole word is committed in a single clock. To read a word, software fetches the lower byte first, which also freezes the upper byte into the staging byte. It then fetches the upper byte. The compare registers are the exception on the read side: their upper byte is read directly. Nothing stops a second access from overwriting the staging byte between the two halves of a first access, and the block reproduces that clash faithfully. A rising edge on the capture input copies the counter into the capture register.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset, every register word and the staging byte are zero, and every read returns zero.
- R2: The address map uses bit 0 as the half select (1 = upper byte). The word pairs are: counter 0/1, compare A 2/3, compare B 4/5, compare C 6/7, capture 8/9. A write to an upper-byte address changes only the staging byte and leaves every word as it was.
- R3: A write to a lower-byte address loads the addressed word in one clock. The upper half of the new word is the staging byte and the lower half is the bus data.
- R4: A read of a lower-byte address returns the live lower byte. In the same clock, it copies that word's live upper byte into the staging byte.
- R5: A read of the counter or capture upper-byte address returns the staging byte, not the live upper byte.
- R6: A read of a compare register's upper-byte address returns the stored upper byte directly, whatever the staging byte holds.
- R7: While the count enable is high, the counter advances by one every clock. A lower-byte write to the counter in the same clock wins over the increment.
- R8: A rising edge on the capture input copies the counter's value in that clock into the capture register. Holding the input high captures nothing more. A lower-byte write to the capture register in the same clock wins over the capture.
- R9: Every word shares the one staging byte. An access to any word between the two halves of another access replaces the staged byte, and the later half then uses the replaced value.
- R10: Addresses 10 to 15 read as zero, and writes to them change neither the staging byte nor any word. When the read strobe is low, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Byte address |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one clock per byte |
| rd_en | input | 1 | Read strobe, one clock per byte |
| rdata | output | 8 | Read data, valid in the clock where rd_en is high |
| cnt_en | input | 1 | Counter enable |
| cap_trig | input | 1 | Capture trigger, acts on its rising edge |

## Verification
Two pairs of functions can fall in the same clock: a lower-byte counter write together with an enabled increment, and a lower-byte capture write together with a rising capture edge. The bench drives each pair in one clock after staging a distinct upper byte. Reading the word back afterwards shows which one won, since only the written value and not the incremented or captured value is accepted. Clashes on the staging byte are provoked by placing a foreign read or write between the halves of a transfer, and they are judged by the corrupted upper byte that the completing half produces.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
    localparam int DATA_W   = 8;
    localparam int WORD_W   = 2 * DATA_W;
    localparam int NUM_CMP  = 3;
    localparam int NUM_REGS = NUM_CMP + 2;
    localparam int ADDR_W   = 4;
    localparam int CNT_IDX  = 0;
    localparam int CAP_IDX  = NUM_CMP + 1;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t [NUM_REGS-1:0] regs;
        byte_t                stage;
    } bank_t;
endpackage

// File: rtl/wrb_addr_decode.sv
module wrb_addr_decode
    import wrb_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel,
    output logic                hi_half,
    output logic                mapped
);
    localparam int IDX_W = ADDR_W - 1;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign sel[g] = (addr[ADDR_W-1:1] == IDX_W'(g));
    end

    assign hi_half = addr[0];
    assign mapped  = |sel;
endmodule

// File: rtl/wrb_edge_detect.sv
module wrb_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/wrb_read_mux.sv
module wrb_read_mux
    import wrb_pkg::*;
(
    input  logic                 rd_en,
    input  logic [NUM_REGS-1:0]  sel,
    input  logic                 hi_half,
    input  word_t [NUM_REGS-1:0] regs,
    input  byte_t                stage,
    output byte_t                rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_en && sel[i]) begin
                if (!hi_half)
                    rdata = regs[i][DATA_W-1:0];
                else if (i >= 1 && i <= NUM_CMP)
                    rdata = regs[i][WORD_W-1:DATA_W];
                else
                    rdata = stage;
            end
        end
    end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
    import wrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic              cnt_en,
    input  logic              cap_trig
);
    bank_t               bank_d, bank_q;
    logic [NUM_REGS-1:0] sel;
    logic                hi_half;
    logic                mapped;
    logic                cap_rise;

    wrb_addr_decode u_decode (
        .addr    (addr),
        .sel     (sel),
        .hi_half (hi_half),
        .mapped  (mapped)
    );

    wrb_edge_detect u_cap_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (cap_trig),
        .rise  (cap_rise)
    );

    wrb_read_mux u_rmux (
        .rd_en   (rd_en),
        .sel     (sel),
        .hi_half (hi_half),
        .regs    (bank_q.regs),
        .stage   (bank_q.stage),
        .rdata   (rdata)
    );

    // Later assignments override earlier ones: bus writes beat hardware events.
    always_comb begin
        bank_d = bank_q;
        if (cnt_en)
            bank_d.regs[CNT_IDX] = bank_q.regs[CNT_IDX] + WORD_W'(1);
        if (cap_rise)
            bank_d.regs[CAP_IDX] = bank_q.regs[CNT_IDX];
        if (rd_en && !hi_half) begin
            for (int i = 0; i < NUM_REGS; i++)
                if (sel[i]) bank_d.stage = bank_q.regs[i][WORD_W-1:DATA_W];
        end
        if (wr_en) begin
            if (hi_half) begin
                if (mapped) bank_d.stage = wdata;
            end else begin
                for (int i = 0; i < NUM_REGS; i++)
                    if (sel[i]) bank_d.regs[i] = {bank_q.stage, wdata};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end
endmodule

// File: rtl/wrb_checker.sv
module wrb_checker
    import wrb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic              cnt_en,
    input bank_t             bank_q
);
    // R2
    hi_write_stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && addr == ADDR_W'(3)) |=>
            ($stable(bank_q.regs[1]) && bank_q.stage == $past(wdata)));

    // R3
    lo_write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(2)) |=>
            (bank_q.regs[1] == {$past(bank_q.stage), $past(wdata)}));

    // R4
    lo_read_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == ADDR_W'(4)) |=>
            (bank_q.stage == $past(bank_q.regs[2][WORD_W-1:DATA_W])));

    // R5
    cnt_hi_from_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(1)) |-> (rdata == bank_q.stage));

    // R6
    cmp_hi_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(5)) |-> (rdata == bank_q.regs[2][WORD_W-1:DATA_W]));

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !(wr_en && addr == ADDR_W'(0))) |=>
            (bank_q.regs[CNT_IDX] == $past(bank_q.regs[CNT_IDX]) + WORD_W'(1)));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr >= ADDR_W'(2 * NUM_REGS)) |-> (rdata == '0));

    // R10
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |-> (rdata == '0));
endmodule

bind wide_reg_bridge wrb_checker u_wrb_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .wdata  (wdata),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .rdata  (rdata),
    .cnt_en (cnt_en),
    .bank_q (bank_q)
);

// File: tb/test_wide_reg_bridge.sv
module test_wide_reg_bridge;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       cnt_en = 1'b0;
    logic       cap_trig = 1'b0;

    item_t queue_q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    wide_reg_bridge i_wide_reg_bridge (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .rdata    (rdata),
        .cnt_en   (cnt_en),
        .cap_trig (cap_trig)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        addr = a; wr_en = 1'b0; rd_en = 1'b1;
        it.exp = e; it.tag = tag;
        queue_q.push_back(it);
    endtask

    task automatic go_idle();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; cnt_en = 1'b0; cap_trig = 1'b0;
    endtask

    // Monitor: sample a quarter period after the falling edge.
    always begin
        @(negedge clk);
        #(CLK_PERIOD / 4);
        if (rst_n && rd_en) begin
            n_checks++;
            if (queue_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: unexpected read, actual %02h expected none", rdata);
            end else begin
                item_t it;
                it = queue_q.pop_front();
                if (rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: addr %0d actual %02h expected %02h", it.tag, addr, rdata, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: all words and the staging byte start at zero
        for (int a = 0; a < 10; a++) bus_read(4'(a), 8'h00, "R1 reset");

        // R2: upper write goes only to staging
        bus_write(4'd3, 8'h42);
        bus_read(4'd3, 8'h00, "R2 word unchanged");
        bus_read(4'd1, 8'h42, "R2 staged byte");

        // R3: lower write commits {stage, data}
        bus_write(4'd2, 8'h17);
        bus_read(4'd2, 8'h17, "R3 low half");
        bus_read(4'd3, 8'h42, "R3 high half");

        // R6 / R5: compare upper byte direct, counter upper byte from staging
        bus_write(4'd5, 8'h5A); bus_write(4'd4, 8'h3C);
        bus_write(4'd7, 8'h99); bus_write(4'd6, 8'hEE);
        bus_read(4'd5, 8'h5A, "R6 compare direct");
        bus_read(4'd1, 8'h99, "R5 counter from stage");

        // R7: count five clocks from 0x1234; R4 snapshot on low read
        bus_write(4'd1, 8'h12); bus_write(4'd0, 8'h34);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; cnt_en = 1'b1;
        repeat (5) @(negedge clk);
        cnt_en = 1'b0;
        bus_read(4'd0, 8'h39, "R7 count low");
        bus_read(4'd1, 8'h12, "R4 snapshot high");

        // R7: lower write beats increment
        bus_write(4'd1, 8'hAB);
        @(negedge clk);
        addr = 4'd0; wdata = 8'hCD; wr_en = 1'b1; rd_en = 1'b0; cnt_en = 1'b1;
        @(negedge clk);
        cnt_en = 1'b0; wr_en = 1'b0;
        bus_read(4'd0, 8'hCD, "R7 write wins low");
        bus_read(4'd1, 8'hAB, "R7 write wins high");

        // R8: single capture on rising edge while counting from 0x0100
        bus_write(4'd1, 8'h01); bus_write(4'd0, 8'h00);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; cnt_en = 1'b1; cap_trig = 1'b1;
        repeat (4) @(negedge clk);
        cnt_en = 1'b0; cap_trig = 1'b0;
        bus_read(4'd8, 8'h00, "R8 capture low");
        bus_read(4'd9, 8'h01, "R8 capture high");
        bus_read(4'd0, 8'h04, "R8 counter ran on");
        bus_read(4'd1, 8'h01, "R8 counter high");

        // R8: lower write beats a capture edge
        bus_write(4'd9, 8'h77);
        @(negedge clk);
        addr = 4'd8; wdata = 8'h88; wr_en = 1'b1; rd_en = 1'b0; cap_trig = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cap_trig = 1'b0;
        bus_read(4'd8, 8'h88, "R8 write wins low");
        bus_read(4'd9, 8'h77, "R8 write wins high");

        // R9: foreign low read between write halves corrupts the word
        bus_write(4'd1, 8'h11);
        bus_read(4'd8, 8'h88, "R9 intruding read");
        bus_write(4'd0, 8'h22);
        bus_read(4'd0, 8'h22, "R9 corrupted low");
        bus_read(4'd1, 8'h77, "R9 corrupted high");
        // R9: foreign write between read halves
        bus_read(4'd0, 8'h22, "R9 read first half");
        bus_write(4'd7, 8'hC3);
        bus_read(4'd1, 8'hC3, "R9 read clobbered");

        // R10: unmapped addresses
        bus_write(4'd11, 8'hFF); bus_write(4'd10, 8'hEE);
        bus_read(4'd1, 8'hC3, "R10 stage untouched");
        bus_read(4'd10, 8'h00, "R10 unmapped 10");
        bus_read(4'd15, 8'h00, "R10 unmapped 15");
        bus_read(4'd0, 8'h22, "R10 counter untouched");

        go_idle();
        repeat (3) @(negedge clk);
        n_checks++;
        if (queue_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", queue_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule